// File: doc/BRIEF.md
# Serial Memory Read Sequencer with CRC-16

This block sits behind a bit-serial slave link and answers a three-byte read request by streaming out the contents of a 128-byte data memory. The link is presented at bit level: a level-sensitive bus reset, a write strobe that carries one incoming bit, and a read-slot strobe that the block answers with one outgoing bit. Every bit travels least significant bit first, in both directions.

A request is a command byte, then the low address byte, then the high address byte. Only the read command (F0h) is recognised. The block returns memory bytes from the given address upward to the last byte. It then sends a 16-bit CRC that covers the command, both address bytes and every data byte sent. After that it answers with ones until the next bus reset. A reset that cuts the read short discards the CRC. The memory is filled through a separate host-side preload port.

The strobes carry no back-pressure: every strobe is accepted in the cycle it is seen. Each strobe is a single-clock pulse. Two read-slot strobes must be at least two clocks apart, so that the next memory byte can be fetched after an address step. The answer to a read slot appears on `rd_bit` with `rd_vld` high in the clock after the strobe.

Top module: `mem_read_seq`

## Requirements
- R1: A request is taken as 8 command bits followed by 16 address bits. Each byte arrives least significant bit first, and the low address byte comes before the high one. The read command code is F0h.
- R2: In the data phase, each read slot returns the next bit of memory, least significant bit first. The first bit comes from the requested byte, and the address advances by one byte after every 8 slots, up to byte 127.
- R3: After bit 7 of byte 127, the next 16 read slots return a CRC-16 with polynomial x^16+x^15+x^2+1, least significant bit first. The CRC is computed bitwise and reflected (feedback constant A001h), starts at zero, and runs over the command byte, both address bytes and each data byte sent, in that order.
- R4: Once the CRC is complete, every further read slot returns 1 until a bus reset.
- R5: A command byte other than F0h makes every read slot return 1 until the next bus reset.
- R6: A request address with any of bits 15 to 7 set makes every read slot return 1 until the next bus reset.
- R7: While `bus_rst` is high, the sequencer returns to waiting for a command within one clock and clears its counters and CRC. A read slot in that cycle returns 1. A read cut short by the reset never produces a CRC, and the next request starts afresh.
- R8: Each read slot is answered with `rd_vld` high exactly one clock after `rd_stb`, and `rd_vld` is low otherwise. During the request phase, read slots return 1 and do not disturb the request.
- R9: A preload write stores `pl_data` at `pl_addr`, and that value is returned by later reads.
- R10: Write strobes received during the data, CRC or all-ones phases have no effect on the returned stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_rst | input | 1 | Level-sensitive bus reset pulse |
| wr_stb | input | 1 | Write-bit strobe, one clock wide |
| wr_bit | input | 1 | Incoming bit, qualified by `wr_stb` |
| rd_stb | input | 1 | Read-slot strobe, one clock wide |
| rd_vld | output | 1 | Answer valid, one clock after `rd_stb` |
| rd_bit | output | 1 | Answer bit for the read slot |
| pl_we | input | 1 | Preload write enable |
| pl_addr | input | 7 | Preload byte address |
| pl_data | input | 8 | Preload byte |

## Verification
A bus reset and the read slot that carries the last bit of byte 127 can arrive in the same clock: the read slot would move the sequencer into the CRC phase, while the reset would send it back to waiting for a command. The bench provokes this by reading the first seven bits of byte 127 and then raising `rd_stb` and `bus_rst` together. It expects a 1 for that slot, and a 1 again for the next slot. If the CRC phase had been entered, that next slot would return bit 0 of the cleared CRC, which is 0. A fresh request that follows must then return the correct data and CRC.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
  typedef enum logic [2:0] {
    ST_CMD  = 3'd0,
    ST_ADDR = 3'd1,
    ST_DATA = 3'd2,
    ST_CRC  = 3'd3,
    ST_ONES = 3'd4
  } state_t;

  localparam int REQ_AW = 16;
  localparam int CRC_W  = 16;
endpackage

// File: rtl/mrs_mem.sv
module mrs_mem #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) arr[waddr] <= wdata;
    q <= arr[raddr];
  end
endmodule

// File: rtl/mrs_crc16.sv
module mrs_crc16 #(
  parameter int          W      = 16,
  parameter logic [15:0] POLY_R = 16'hA001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         din,
  input  logic         shr,
  output logic [W-1:0] crc
);
  logic         fb;
  logic [W-1:0] nxt;

  always_comb begin
    fb  = crc[0] ^ din;
    nxt = {1'b0, crc[W-1:1]};
    if (fb) nxt = nxt ^ POLY_R[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= '0;
    else if (clr) crc <= '0;
    else if (en)  crc <= nxt;
    else if (shr) crc <= {1'b1, crc[W-1:1]};
  end
endmodule

// File: rtl/mem_read_seq.sv
module mem_read_seq #(
  parameter int          AW     = 7,
  parameter int          DW     = 8,
  parameter logic [7:0]  CMD_RD = 8'hF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_rst,
  input  logic          wr_stb,
  input  logic          wr_bit,
  input  logic          rd_stb,
  output logic          rd_vld,
  output logic          rd_bit,
  input  logic          pl_we,
  input  logic [AW-1:0] pl_addr,
  input  logic [DW-1:0] pl_data
);
  import mrs_pkg::*;

  localparam int CW = $clog2(REQ_AW);
  localparam int BW = $clog2(DW);

  state_t              state;
  logic [CW-1:0]       cnt;
  logic [DW-1:0]       csh;
  logic [REQ_AW-1:0]   ash;
  logic [AW-1:0]       byte_addr;
  logic [DW-1:0]       mem_q;
  logic [CRC_W-1:0]    crc;

  logic [DW-1:0]       cmd_nx;
  logic [REQ_AW-1:0]   addr_nx;
  logic                byte_end;
  logic                addr_end;
  logic                last_byte;
  logic                data_bit;
  logic                crc_en;
  logic                crc_din;
  logic                crc_shr;
  logic                bit_nx;

  mrs_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk   (clk),
    .we    (pl_we),
    .waddr (pl_addr),
    .wdata (pl_data),
    .raddr (byte_addr),
    .q     (mem_q)
  );

  mrs_crc16 #(.W(CRC_W)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (bus_rst),
    .en    (crc_en),
    .din   (crc_din),
    .shr   (crc_shr),
    .crc   (crc)
  );

  always_comb begin
    cmd_nx    = {wr_bit, csh[DW-1:1]};
    addr_nx   = {wr_bit, ash[REQ_AW-1:1]};
    byte_end  = (cnt == CW'(DW - 1));
    addr_end  = (cnt == CW'(REQ_AW - 1));
    last_byte = (byte_addr == {AW{1'b1}});
    data_bit  = mem_q[cnt[BW-1:0]];
    crc_din   = (state == ST_DATA) ? data_bit : wr_bit;
    crc_en    = !bus_rst &&
                ((wr_stb && (state == ST_CMD || state == ST_ADDR)) ||
                 (rd_stb && state == ST_DATA));
    crc_shr   = !bus_rst && rd_stb && (state == ST_CRC);
    case (state)
      ST_DATA: bit_nx = data_bit;
      ST_CRC:  bit_nx = crc[0];
      default: bit_nx = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld <= 1'b0;
      rd_bit <= 1'b1;
    end else begin
      rd_vld <= rd_stb;
      rd_bit <= bus_rst ? 1'b1 : bit_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_CMD;
      cnt       <= '0;
      csh       <= '0;
      ash       <= '0;
      byte_addr <= '0;
    end else if (bus_rst) begin
      state     <= ST_CMD;
      cnt       <= '0;
      csh       <= '0;
      ash       <= '0;
      byte_addr <= '0;
    end else begin
      case (state)
        ST_CMD: if (wr_stb) begin
          csh <= cmd_nx;
          cnt <= cnt + 1'b1;
          if (byte_end) begin
            cnt   <= '0;
            state <= (cmd_nx == CMD_RD) ? ST_ADDR : ST_ONES;
          end
        end
        ST_ADDR: if (wr_stb) begin
          ash <= addr_nx;
          cnt <= cnt + 1'b1;
          if (addr_end) begin
            cnt       <= '0;
            byte_addr <= addr_nx[AW-1:0];
            state     <= (addr_nx[REQ_AW-1:AW] == '0) ? ST_DATA : ST_ONES;
          end
        end
        ST_DATA: if (rd_stb) begin
          cnt <= cnt + 1'b1;
          if (byte_end) begin
            cnt <= '0;
            if (last_byte) state <= ST_CRC;
            else           byte_addr <= byte_addr + 1'b1;
          end
        end
        ST_CRC: if (rd_stb) begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(CRC_W - 1)) begin
            cnt   <= '0;
            state <= ST_ONES;
          end
        end
        default: state <= ST_ONES;
      endcase
    end
  end
endmodule

// File: rtl/mrs_chk.sv
module mrs_chk #(
  parameter int         AW     = 7,
  parameter int         DW     = 8,
  parameter int         CW     = 4,
  parameter logic [7:0] CMD_RD = 8'hF0
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_rst,
  input logic            wr_stb,
  input logic            wr_bit,
  input logic            rd_stb,
  input logic            rd_vld,
  input logic            rd_bit,
  input mrs_pkg::state_t state,
  input logic [CW-1:0]   cnt,
  input logic [DW-1:0]   csh,
  input logic [AW-1:0]   byte_addr
);
  import mrs_pkg::*;

  AST_BUS_RST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (state == ST_CMD && cnt == '0)); // R7

  AST_SLOT_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_vld); // R8

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !rd_vld); // R8

  AST_REQ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && (state == ST_CMD || state == ST_ADDR)) |=> rd_bit); // R8

  AST_IDLE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && state == ST_ONES) |=> rd_bit); // R4

  AST_ONES_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rst && state == ST_ONES) |=> state == ST_ONES); // R4

  AST_BAD_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rst && state == ST_CMD && wr_stb && cnt == CW'(DW - 1) &&
     {wr_bit, csh[DW-1:1]} != CMD_RD) |=> state == ST_ONES); // R5

  AST_END_TO_CRC: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rst && state == ST_DATA && rd_stb && cnt == CW'(DW - 1) &&
     byte_addr == {AW{1'b1}}) |=> (state == ST_CRC && cnt == '0)); // R3

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rst && state == ST_DATA && rd_stb && cnt == CW'(DW - 1) &&
     byte_addr != {AW{1'b1}}) |=> byte_addr == $past(byte_addr) + 1'b1); // R2
endmodule

bind mem_read_seq mrs_chk #(.AW(AW), .DW(DW), .CW(CW), .CMD_RD(CMD_RD)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rst   (bus_rst),
  .wr_stb    (wr_stb),
  .wr_bit    (wr_bit),
  .rd_stb    (rd_stb),
  .rd_vld    (rd_vld),
  .rd_bit    (rd_bit),
  .state     (state),
  .cnt       (cnt),
  .csh       (csh),
  .byte_addr (byte_addr)
);

// File: tb/sim_mem_read_seq.sv
`timescale 1ns/1ps
module sim_mem_read_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_rst = 1'b0;
  logic       wr_stb = 1'b0;
  logic       wr_bit = 1'b0;
  logic       rd_stb = 1'b0;
  logic       rd_vld;
  logic       rd_bit;
  logic       pl_we = 1'b0;
  logic [6:0] pl_addr = '0;
  logic [7:0] pl_data = '0;

  logic [7:0] model [128];
  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mem_read_seq u0 (
    .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst),
    .wr_stb(wr_stb), .wr_bit(wr_bit), .rd_stb(rd_stb),
    .rd_vld(rd_vld), .rd_bit(rd_bit),
    .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data)
  );

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ 16'hA001;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic preload(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    pl_we = 1'b1; pl_addr = a; pl_data = d;
    @(negedge clk);
    pl_we = 1'b0;
    model[a] = d;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    wr_stb = 1'b1; wr_bit = b;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
  endtask

  task automatic read_bit(output logic v);
    @(negedge clk);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    v = rd_bit;
    if (rd_vld !== 1'b1) begin
      vectors++; fails++;
      $display("FAIL R8: rd_vld got %b expected 1", rd_vld);
    end
    @(negedge clk);
  endtask

  task automatic read_byte(output logic [7:0] b);
    logic v;
    for (int i = 0; i < 8; i++) begin
      read_bit(v);
      b[i] = v;
    end
  endtask

  task automatic pulse_bus_rst();
    @(negedge clk); bus_rst = 1'b1;
    @(negedge clk); bus_rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_ones(input string req, input int n);
    logic v;
    for (int i = 0; i < n; i++) begin
      read_bit(v);
      check(req, v, 1);
    end
  endtask

  // reads from address a to byte 127, then the CRC, then trailing ones
  task automatic read_rest(input int a, input logic [15:0] c0);
    logic [15:0] c, got;
    logic [7:0] b;
    logic v;
    c = c0;
    for (int i = a; i < 128; i++) begin
      read_byte(b);
      check("R2 data byte", b, model[i]);
      c = crc_byte(c, model[i]);
    end
    for (int i = 0; i < 16; i++) begin
      read_bit(v);
      got[i] = v;
    end
    check("R3 crc", got, c);
    read_ones("R4 ones after crc", 3);
  endtask

  task automatic run_read(input logic [15:0] a);
    logic [15:0] c;
    send_byte(8'hF0);
    send_byte(a[7:0]);
    send_byte(a[15:8]);
    c = crc_byte(crc_byte(crc_byte(16'h0, 8'hF0), a[7:0]), a[15:8]);
    read_rest(int'(a[6:0]), c);
    pulse_bus_rst();
  endtask

  task automatic t_reset();
    check("R8 rd_vld at reset", rd_vld, 0);
    check("R7 rd_bit at reset", rd_bit, 1);
  endtask

  task automatic t_full_read();
    run_read(16'h0000); // R1 R2 R3 R4
    run_read(16'h007A); // R1 low byte first
  endtask

  task automatic t_bad_cmd();
    send_byte(8'hE1);
    read_ones("R5 bad command", 10);
    send_byte(8'hF0);
    read_ones("R5 sticky after bad command", 4);
    pulse_bus_rst();
  endtask

  task automatic t_bad_addr();
    send_byte(8'hF0); send_byte(8'h80); send_byte(8'h00);
    read_ones("R6 addr bit 7 set", 10);
    pulse_bus_rst();
    send_byte(8'hF0); send_byte(8'h05); send_byte(8'h01);
    read_ones("R6 addr bit 8 set", 10);
    pulse_bus_rst();
  endtask

  task automatic t_slot_during_request();
    logic [15:0] c;
    logic v;
    send_byte(8'hF0);
    read_bit(v);
    check("R8 slot in request phase", v, 1);
    send_byte(8'h7C);
    read_bit(v);
    check("R8 slot between address bytes", v, 1);
    send_byte(8'h00);
    c = crc_byte(crc_byte(crc_byte(16'h0, 8'hF0), 8'h7C), 8'h00);
    read_rest(124, c);
    pulse_bus_rst();
  endtask

  task automatic t_writes_ignored();
    logic [15:0] c;
    logic [7:0] b;
    send_byte(8'hF0); send_byte(8'h7D); send_byte(8'h00);
    c = crc_byte(crc_byte(crc_byte(16'h0, 8'hF0), 8'h7D), 8'h00);
    read_byte(b);
    check("R10 first byte", b, model[125]);
    c = crc_byte(c, model[125]);
    send_byte(8'h3C); // R10 writes in data phase
    read_rest(126, c);
    send_byte(8'hF0); // R10 writes in ones phase
    read_ones("R10 ones unaffected", 4);
    pulse_bus_rst();
  endtask

  task automatic t_truncate_and_clash();
    logic [7:0] b;
    logic v;
    send_byte(8'hF0); send_byte(8'h10); send_byte(8'h00);
    read_byte(b);
    check("R2 truncated read byte", b, model[16]);
    pulse_bus_rst();
    read_bit(v);
    check("R7 no crc after truncated read", v, 1);
    // reset clashes with the read slot of the final data bit
    send_byte(8'hF0); send_byte(8'h7F); send_byte(8'h00);
    for (int i = 0; i < 7; i++) begin
      read_bit(v);
      check("R2 byte 127 bit", v, model[127][i]);
    end
    @(negedge clk); rd_stb = 1'b1; bus_rst = 1'b1;
    @(negedge clk); rd_stb = 1'b0; bus_rst = 1'b0;
    check("R7 slot during reset", rd_bit, 1);
    @(negedge clk);
    read_bit(v);
    check("R7 crc phase not entered", v, 1);
    run_read(16'h007E);
  endtask

  task automatic t_preload();
    preload(7'd127, 8'hA5); // R9
    preload(7'd126, 8'h0F); // R9
    run_read(16'h007E);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    for (int i = 0; i < 128; i++) preload(7'(i), 8'((i * 37 + 5) & 8'hFF));
    t_full_read();
    t_bad_cmd();
    t_bad_addr();
    t_slot_during_request();
    t_writes_ignored();
    t_truncate_and_clash();
    t_preload();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule